// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block produces the 14-bit instruction fetch address for a small pipelined controller core. The core's clock runs four times faster than its instruction rate. The block therefore holds its address steady for a whole instruction cycle and changes it only on the clock where the cycle strobe is high. The core fetches one instruction while it executes the one fetched before. So whenever the address leaves plain sequential order, the word already fetched is stale, and the block raises a flush flag for the following instruction cycle.

On each strobe the block picks the next address from one source, taken in this order:

1. An interrupt vector.
2. A return value from the call stack.
3. A call target or a jump target, each formed with a bank-select bit on top.
4. A byte written into the low address byte.
5. A skip, which stays inside the current bank.
6. The plain increment.

On a call or an interrupt entry, the block emits the return address for the external stack with a one-clock strobe. The stack, interrupt arbitration and instruction decode all live outside. Every pin is plain level or strobe signalling with no back-pressure. The stack must accept a push in the clock where the push strobe is high, and requests must be held stable through the strobe clock.

Top module: `pc_sequencer`

## Requirements
- R1: While rst_n is low, and until the first strobe after it rises, pc_o is 0x0000, and flush_o and push_stb_o are 0.
- R2: pc_o changes only on a rising clock edge where cyc_stb_i is high. With no accepted request, it becomes pc_o+1, wrapping from 0x3FFF to 0x0000.
- R3: An interrupt with irq_src_i = k, for k in 0..5, loads (k+1)*4 (0x004 to 0x018). irq_src_i values 6 and 7 are ignored, as though irq_i were low.
- R4: When several requests are accepted in the same strobe, only one is applied. The order is interrupt, then return, then call, then jump, then low-byte write, then skip.
- R5: A skip loads {pc_o[13], pc_o[12:0]+2}, so bit 13 never changes.
- R6: A low-byte write loads {pc_o[13:8], pcl_data_i}.
- R7: A jump or a call loads {bank_sel_i, tgt_i[12:0]}.
- R8: A return loads all 14 bits of ret_addr_i.
- R9: flush_o is 1 for exactly the instruction cycle that follows a strobe applying any source other than the increment. It is 0 after an increment strobe.
- R10: While flush_o is 1, skip_i, pcl_we_i, jmp_i, call_i and ret_i are ignored, and the PC increments. An interrupt is still applied.
- R11: After a strobe that applies a call or an interrupt, push_stb_o is 1 for one clock and push_addr_o holds the pc_o value from before that strobe. In all other cases push_stb_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (four per instruction cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb_i | input | 1 | Instruction-cycle strobe; requests are sampled and the PC is updated on this clock |
| irq_i | input | 1 | Interrupt entry request |
| irq_src_i | input | 3 | Interrupt source index, 0..5 valid |
| skip_i | input | 1 | Skip request |
| pcl_we_i | input | 1 | Low address byte write |
| pcl_data_i | input | 8 | Byte for the low address write |
| jmp_i | input | 1 | Jump request |
| call_i | input | 1 | Call request |
| tgt_i | input | 13 | Jump or call target field |
| ret_i | input | 1 | Return request |
| ret_addr_i | input | 14 | Stack top value for a return |
| bank_sel_i | input | 1 | Bank bit placed on top of jump and call targets |
| pc_o | output | 14 | Current fetch address |
| push_stb_o | output | 1 | One-clock push strobe to the stack |
| push_addr_o | output | 14 | Return address to push |
| flush_o | output | 1 | Discard the instruction fetched in this cycle |

## Verification
The assertions watch the properties that hold on every clock:

- the PC and flush flag stay stable between strobes;
- a strobe during a flush cycle without an interrupt can only increment;
- a skip never alters the bank bit;
- every push follows a strobe;
- an interrupt vector is always word-aligned.

Only the bench's scenarios can show the exact address each source produces and the priority among simultaneous requests. The same holds for the ignoring of out-of-range interrupt sources, both wrap points, and the pushed return value, which the bench compares against its reference on every clock.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_SKIP = 3'd1,
    SRC_PCL  = 3'd2,
    SRC_JMP  = 3'd3,
    SRC_CALL = 3'd4,
    SRC_RET  = 3'd5,
    SRC_IRQ  = 3'd6
  } pc_src_e;

  function automatic logic src_pushes(input pc_src_e s);
    return (s == SRC_CALL) || (s == SRC_IRQ);
  endfunction
endpackage

// File: rtl/pcs_src_sel.sv
`timescale 1ns/1ps
module pcs_src_sel
  import pcs_pkg::*;
#(
  parameter int SRC_W = 3,
  parameter int IRQ_N = 6
) (
  input  logic             irq_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic             ret_i,
  input  logic             call_i,
  input  logic             jmp_i,
  input  logic             pcl_we_i,
  input  logic             skip_i,
  input  logic             squash_i,
  output pc_src_e          src_o
);
  localparam int SRC_LIM = IRQ_N;

  logic irq_ok;
  logic instr_ok;

  assign irq_ok   = irq_i && (int'(irq_src_i) < SRC_LIM);
  assign instr_ok = !squash_i;

  always_comb begin
    if (irq_ok)                  src_o = SRC_IRQ;
    else if (instr_ok && ret_i)  src_o = SRC_RET;
    else if (instr_ok && call_i) src_o = SRC_CALL;
    else if (instr_ok && jmp_i)  src_o = SRC_JMP;
    else if (instr_ok && pcl_we_i) src_o = SRC_PCL;
    else if (instr_ok && skip_i) src_o = SRC_SKIP;
    else                         src_o = SRC_INC;
  end
endmodule

// File: rtl/pcs_addr_gen.sv
`timescale 1ns/1ps
module pcs_addr_gen
  import pcs_pkg::*;
#(
  parameter int PC_W      = 14,
  parameter int LIT_W     = 13,
  parameter int PCL_W     = 8,
  parameter int SRC_W     = 3,
  parameter int VEC_SHIFT = 2,
  parameter int SKIP_STEP = 2
) (
  input  pc_src_e          src_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic [PCL_W-1:0] pcl_data_i,
  input  logic [LIT_W-1:0] tgt_i,
  input  logic             bank_i,
  input  logic [PC_W-1:0]  ret_addr_i,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam int LOW_W = PC_W - 1;
  localparam int HI_W  = PC_W - PCL_W;

  logic [PC_W-1:0]  vec_addr;
  logic [LOW_W-1:0] skip_low;
  logic [PC_W-1:0]  jump_addr;

  assign vec_addr = (PC_W'(irq_src_i) + PC_W'(1)) << VEC_SHIFT;
  assign skip_low = pc_i[LOW_W-1:0] + LOW_W'(SKIP_STEP);

  generate
    if (LIT_W >= LOW_W) begin : g_full_lit
      assign jump_addr = {bank_i, tgt_i[LOW_W-1:0]};
    end else begin : g_short_lit
      assign jump_addr = {bank_i, (LOW_W-LIT_W)'(0), tgt_i};
    end
  endgenerate

  always_comb begin
    unique case (src_i)
      SRC_IRQ:           next_pc_o = vec_addr;
      SRC_RET:           next_pc_o = ret_addr_i;
      SRC_CALL, SRC_JMP: next_pc_o = jump_addr;
      SRC_PCL:           next_pc_o = {pc_i[PC_W-1 -: HI_W], pcl_data_i};
      SRC_SKIP:          next_pc_o = {pc_i[PC_W-1], skip_low};
      default:           next_pc_o = pc_i + PC_W'(1);
    endcase
  end

  // R3: vectors are word aligned
  always_comb begin
    if (src_i == SRC_IRQ) begin
      a_r3_vec_align: assert (next_pc_o[VEC_SHIFT-1:0] == '0);
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int PC_W      = 14,
  parameter int LIT_W     = 13,
  parameter int PCL_W     = 8,
  parameter int SRC_W     = 3,
  parameter int IRQ_N     = 6,
  parameter int VEC_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb_i,
  input  logic             irq_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic             skip_i,
  input  logic             pcl_we_i,
  input  logic [PCL_W-1:0] pcl_data_i,
  input  logic             jmp_i,
  input  logic             call_i,
  input  logic [LIT_W-1:0] tgt_i,
  input  logic             ret_i,
  input  logic [PC_W-1:0]  ret_addr_i,
  input  logic             bank_sel_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             push_stb_o,
  output logic [PC_W-1:0]  push_addr_o,
  output logic             flush_o
);
  pc_src_e         src;
  logic [PC_W-1:0] next_pc;

  pcs_src_sel #(.SRC_W(SRC_W), .IRQ_N(IRQ_N)) u_sel (
    .irq_i     (irq_i),
    .irq_src_i (irq_src_i),
    .ret_i     (ret_i),
    .call_i    (call_i),
    .jmp_i     (jmp_i),
    .pcl_we_i  (pcl_we_i),
    .skip_i    (skip_i),
    .squash_i  (flush_o),
    .src_o     (src)
  );

  pcs_addr_gen #(
    .PC_W(PC_W), .LIT_W(LIT_W), .PCL_W(PCL_W),
    .SRC_W(SRC_W), .VEC_SHIFT(VEC_SHIFT), .SKIP_STEP(2)
  ) u_gen (
    .src_i      (src),
    .pc_i       (pc_o),
    .irq_src_i  (irq_src_i),
    .pcl_data_i (pcl_data_i),
    .tgt_i      (tgt_i),
    .bank_i     (bank_sel_i),
    .ret_addr_i (ret_addr_i),
    .next_pc_o  (next_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o        <= '0;
      flush_o     <= 1'b0;
      push_stb_o  <= 1'b0;
      push_addr_o <= '0;
    end else begin
      push_stb_o <= 1'b0;
      if (cyc_stb_i) begin
        pc_o    <= next_pc;
        flush_o <= (src != SRC_INC);
        if (src_pushes(src)) begin
          push_stb_o  <= 1'b1;
          push_addr_o <= pc_o;
        end
      end
    end
  end

  // R2: address held between strobes
  a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb_i |=> $stable(pc_o));

  // R9: flush flag lasts the whole instruction cycle
  a_r9_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_stb_i |=> $stable(flush_o));

  // R10: stale instruction cannot redirect
  a_r10_squash_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb_i && flush_o && !irq_i) |=> (pc_o == $past(pc_o) + PC_W'(1)) && !flush_o);

  // R5: skip keeps the bank bit
  a_r5_bank_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb_i && src == SRC_SKIP) |=> pc_o[PC_W-1] == $past(pc_o[PC_W-1]));

  // R11: a push only follows a strobe
  a_r11_push_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    push_stb_o |-> $past(cyc_stb_i));
endmodule

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_stb = 1'b0;
  logic        irq = 1'b0;
  logic [2:0]  irq_src = '0;
  logic        skip = 1'b0;
  logic        pcl_we = 1'b0;
  logic [7:0]  pcl_data = '0;
  logic        jmp = 1'b0;
  logic        call = 1'b0;
  logic [12:0] tgt = '0;
  logic        ret = 1'b0;
  logic [13:0] ret_addr = '0;
  logic        bank = 1'b0;
  logic [13:0] pc;
  logic        push_stb;
  logic [13:0] push_addr;
  logic        flush;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb_i(cyc_stb), .irq_i(irq),
    .irq_src_i(irq_src), .skip_i(skip), .pcl_we_i(pcl_we),
    .pcl_data_i(pcl_data), .jmp_i(jmp), .call_i(call), .tgt_i(tgt),
    .ret_i(ret), .ret_addr_i(ret_addr), .bank_sel_i(bank), .pc_o(pc),
    .push_stb_o(push_stb), .push_addr_o(push_addr), .flush_o(flush)
  );

  // reference model
  int    m_pc, m_pa;
  bit    m_fl, m_ps;
  string m_tag;
  int    t_np, t_n;
  bit    t_irq_ok, t_ok, t_push, t_ns;
  string t_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc <= 0; m_fl <= 0; m_ps <= 0; m_pa <= 0; m_tag <= "R1";
    end else begin
      m_ps <= 0;
      if (cyc_stb) begin
        t_irq_ok = irq && (irq_src <= 5);
        t_ok = !m_fl;
        t_push = 0; t_ns = 1;
        t_n = int'(t_irq_ok) + (t_ok ? int'(ret) + int'(call) + int'(jmp) + int'(pcl_we) + int'(skip) : 0);
        if (t_irq_ok) begin
          t_np = (int'(irq_src) + 1) * 4; t_push = 1; t_tag = "R3";
        end else if (t_ok && ret) begin
          t_np = int'(ret_addr); t_tag = "R8";
        end else if (t_ok && (call || jmp)) begin
          t_np = int'(bank) * 8192 + int'(tgt); t_push = call; t_tag = "R7";
        end else if (t_ok && pcl_we) begin
          t_np = (m_pc & 'h3F00) | int'(pcl_data); t_tag = "R6";
        end else if (t_ok && skip) begin
          t_np = (m_pc & 'h2000) | ((m_pc + 2) & 'h1FFF); t_tag = "R5";
        end else begin
          t_np = (m_pc + 1) & 'h3FFF; t_ns = 0;
          t_tag = (m_fl && (ret || call || jmp || pcl_we || skip)) ? "R10" : "R2";
        end
        if (t_n > 1) t_tag = "R4";
        m_pc <= t_np; m_fl <= t_ns; m_tag <= t_tag;
        if (t_push) begin m_ps <= 1; m_pa <= m_pc; end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(m_tag, int'(pc), m_pc);
    check("R9", int'(flush), int'(m_fl));
    check("R11", int'(push_stb), int'(m_ps));
    if (m_ps) check("R11", int'(push_addr), m_pa);
  end

  task automatic clear_req();
    irq = 0; skip = 0; pcl_we = 0; jmp = 0; call = 0; ret = 0;
  endtask

  // one instruction cycle: strobe on the fourth clock
  task automatic icyc();
    cyc_stb = 0;
    repeat (3) @(negedge clk);
    cyc_stb = 1;
    @(negedge clk);
    cyc_stb = 0;
    clear_req();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);          // R1 reset state compared here
    rst_n = 1;
    repeat (4) icyc();                  // R2 increments
    jmp = 1; bank = 1; tgt = 13'h1FFF; icyc();   // R7 -> 0x3FFF
    icyc();                             // flush cycle, R9
    icyc();                             // R2 wrap 0x3FFF->0x0000? (pc was 0x3FFF+1)
    jmp = 1; bank = 1; tgt = 13'h1FFE; icyc();   // 0x3FFE
    icyc();
    skip = 1; icyc();                   // R5 0x3FFF -> 0x2001
    skip = 1; icyc();                   // R10 ignored in flush
    pcl_we = 1; pcl_data = 8'hA5; icyc(); // R6
    icyc();
    call = 1; bank = 0; tgt = 13'h0123; icyc(); // R7 + R11 push
    icyc();
    ret = 1; ret_addr = 14'h2ABC; icyc();        // R8
    icyc();
    for (int k = 0; k < 8; k++) begin   // R3 every source, 6/7 ignored
      irq = 1; irq_src = 3'(k); icyc();
      irq = 1; irq_src = 3'((k + 1) % 6); icyc(); // irq served during flush, R10
      icyc();
    end
    irq = 1; irq_src = 3'd2; ret = 1; call = 1; jmp = 1; pcl_we = 1; skip = 1; icyc(); // R4
    icyc();
    ret = 1; call = 1; ret_addr = 14'h1234; icyc(); // R4 ret over call
    icyc();
    call = 1; jmp = 1; tgt = 13'h0456; icyc();      // R4 call over jump
    icyc();
    pcl_we = 1; skip = 1; pcl_data = 8'h10; icyc(); // R4 pcl over skip
    icyc();
    irq = 1; irq_src = 3'd7; jmp = 1; tgt = 13'h0777; icyc(); // R3 bad source ignored
    icyc();
    for (int i = 0; i < 600; i++) begin
      irq      = ($urandom % 8) == 0;
      irq_src  = 3'($urandom);
      skip     = ($urandom % 5) == 0;
      pcl_we   = ($urandom % 6) == 0;
      pcl_data = 8'($urandom);
      jmp      = ($urandom % 6) == 0;
      call     = ($urandom % 7) == 0;
      tgt      = 13'($urandom);
      ret      = ($urandom % 7) == 0;
      ret_addr = 14'($urandom);
      bank     = 1'($urandom);
      icyc();
      if (i == 300) begin               // R1 mid-run reset
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
      end
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule